// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits between a synchronous request port and an asynchronous pseudo-static RAM. Each request carries an address, a 16-bit write word, a two-bit lane mask and a direction. The block turns it into one chip-enable-controlled bus cycle on the memory pins. The data bus is modelled as a separate output word, a drive enable and an input word, so the pad cell stays outside the block. Every timing limit is a nanosecond parameter. Each limit is converted to a whole number of system clock cycles, rounding up, for the clock period given.

The memory hides its self-refresh in deselected time and in full-length cycles. For that reason, every access has the same fixed length and is followed by a forced deselect gap. The chip enable is never held low for longer than the open-cycle limit. A request whose lane mask is all zero completes at once and causes no pin activity.

The state machine has five states:
- `ST_IDLE` waits for a request. On the transition ACCEPT it goes to `ST_ARM`. On the transition SKIP, taken for a zero mask, it stays in `ST_IDLE`.
- `ST_ARM` puts the new address on the pins while chip enable stays high. It then takes LAUNCH_RD to `ST_READ` or LAUNCH_WR to `ST_WRITE`.
- `ST_READ` and `ST_WRITE` last a counted number of cycles. When the count ends they take CLOSE to `ST_GAP`.
- `ST_GAP` holds every strobe high for the deselect count. It then takes REOPEN back to `ST_IDLE`.

Top module: `psram_ctrl`

## Requirements
- R1: Out of reset, chip enable, output enable, write enable and both lane enables are high, the data drive enable is low and `req_ready` is high.
- R2: An accepted request with a nonzero mask spends one cycle with the new address on `mem_addr` and chip enable high. The address is therefore unchanged at the cycle in which chip enable falls.
- R3: A read holds chip enable and output enable low for exactly N_RD = max(ceil(70 ns), ceil(35 ns)) clock cycles, which is 14 at 5 ns. Data is sampled on the last of those edges. `rsp_valid` pulses for one cycle, 15 cycles after the accepting edge at the defaults. Lanes outside the mask read as zero.
- R4: A write holds chip enable, write enable and the selected lane enables low for exactly N_WR cycles, the largest of the rounded 70, 60, 60, 50 and 25 ns limits (14 at 5 ns). All of these strobes rise on the same edge. The write word is driven through the whole pulse and on the cycle after it.
- R5: Mask bit 0 selects the lower lane enable and data bits 7:0. Mask bit 1 selects the upper lane enable and data bits 15:8.
- R6: After every access, chip enable and both lane enables stay high for at least N_DES = ceil(15 ns) cycles before chip enable falls again.
- R7: The data bus is never driven while output enable is low. It is released at least one cycle before output enable falls.
- R8: A request with mask 00 is accepted without any chip-enable activity, and `req_ready` stays high. A read of this kind gives `rsp_valid` with zero data on the cycle right after the accepting edge.
- R9: Chip enable never stays low for N_OPEN = 40000 ns / period cycles or more.
- R10: `req_ready` is high only in `ST_IDLE`, where all strobes are high. Two back-to-back accesses are accepted 1 + N + N_DES + 1 cycles apart, which is 19 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_lanes | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle read completion strobe |
| rsp_rdata | output | DATA_W | Read word, unselected lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data returned by memory |

## Verification
The end of a read coincides with several events on the same edge. On that edge the data is sampled, the `rsp_valid` pulse is launched, chip enable rises to start the deselect gap, and a waiting request may still be held on the port. The bench provokes this by presenting each next request immediately after the previous one, so it stays valid through the response and the gap.

The judgement comes from two sources. The memory model returns a wrong marker value if the data is sampled before the full chip-enable and output-enable windows have elapsed. The acceptance spacing and the response latency are measured in cycles and compared with the counts stated in R3 and R10.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_READ,
        ST_WRITE,
        ST_GAP
    } psram_state_e;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_span_timer.sv
module psram_span_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/psram_lane_map.sv
module psram_lane_map #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              active,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] raw,
    output logic [LANES-1:0]  lane_n,
    output logic [DATA_W-1:0] masked
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = !(active && lane_sel[g]);
        assign masked[g*LANE_W +: LANE_W] = lane_sel[g] ? raw[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int DATA_W         = 16,
    parameter int CLK_PERIOD_NS  = 5,
    parameter int T_CYCLE_NS     = 70,
    parameter int T_DESEL_NS     = 15,
    parameter int T_OE_ACC_NS    = 35,
    parameter int T_WE_PULSE_NS  = 50,
    parameter int T_CE_WR_NS     = 60,
    parameter int T_LANE_WR_NS   = 60,
    parameter int T_DSETUP_NS    = 25,
    parameter int T_OPEN_MAX_NS  = 40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_lanes,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int LANES  = 2;
    localparam int N_RD   = max_of(ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS),
                                   ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int N_WR   = max_of(max_of(ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS)),
                                   max_of(max_of(ns_to_cycles(T_CE_WR_NS, CLK_PERIOD_NS),
                                                 ns_to_cycles(T_LANE_WR_NS, CLK_PERIOD_NS)),
                                          ns_to_cycles(T_DSETUP_NS, CLK_PERIOD_NS)));
    localparam int N_DES  = max_of(ns_to_cycles(T_DESEL_NS, CLK_PERIOD_NS), 1);
    localparam int N_OPEN = T_OPEN_MAX_NS / CLK_PERIOD_NS;
    localparam int CNT_W  = $clog2(max_of(max_of(N_RD, N_WR), N_DES) + 1);
    localparam int OPEN_W = $clog2(N_OPEN + 2);

    psram_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [LANES-1:0]  lanes_q, lane_n;
    logic              wr_q, rsp_q;
    logic              accept, expired, tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [DATA_W-1:0] rd_masked;
    logic              bus_active;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: ACCEPT, SKIP, LAUNCH_RD, LAUNCH_WR, CLOSE, REOPEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept && (req_lanes != '0)) state_d = ST_ARM;
            ST_ARM:   state_d = wr_q ? ST_WRITE : ST_READ;
            ST_READ:  if (expired) state_d = ST_GAP;
            ST_WRITE: if (expired) state_d = ST_GAP;
            ST_GAP:   if (expired) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Interval timer loads on entry to each counted state
    assign tmr_load = (state_q == ST_ARM) ||
                      (((state_q == ST_READ) || (state_q == ST_WRITE)) && expired);
    assign tmr_val  = (state_q == ST_ARM) ? (wr_q ? CNT_W'(N_WR - 1) : CNT_W'(N_RD - 1))
                                          : CNT_W'(N_DES - 1);

    psram_span_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    assign bus_active = (state_q == ST_READ) || (state_q == ST_WRITE);

    psram_lane_map #(.DATA_W(DATA_W), .LANES(LANES)) lanes_i (
        .active   (bus_active),
        .lane_sel (lanes_q),
        .raw      (mem_dq_in),
        .lane_n   (lane_n),
        .masked   (rd_masked)
    );

    // Request capture and read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
            wr_q    <= 1'b0;
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rsp_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                lanes_q <= req_lanes;
                wr_q    <= req_write;
                if (!req_write && (req_lanes == '0)) begin
                    rsp_q   <= 1'b1;
                    rdata_q <= '0;
                end
            end else if ((state_q == ST_READ) && expired) begin
                rsp_q   <= 1'b1;
                rdata_q <= rd_masked;
            end
        end
    end

    // Output process
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_ce_n   = !bus_active;
        mem_oe_n   = (state_q != ST_READ);
        mem_we_n   = (state_q != ST_WRITE);
        mem_lb_n   = lane_n[0];
        mem_ub_n   = lane_n[1];
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
        mem_dq_oe  = wr_q && ((state_q == ST_ARM) || (state_q == ST_WRITE) ||
                              (state_q == ST_GAP));
        rsp_valid  = rsp_q;
        rsp_rdata  = rdata_q;
    end

    // Pin-level span counters for the checks below
    logic [OPEN_W-1:0] ce_lo_cnt;
    logic [CNT_W-1:0]  ce_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_lo_cnt <= '0;
            ce_hi_cnt <= CNT_W'(N_DES);
        end else begin
            ce_lo_cnt <= mem_ce_n ? '0 : ce_lo_cnt + 1'b1;
            if (!mem_ce_n) ce_hi_cnt <= '0;
            else if (ce_hi_cnt < CNT_W'(N_DES)) ce_hi_cnt <= ce_hi_cnt + 1'b1;
        end
    end

    assert_open_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (ce_lo_cnt < OPEN_W'(N_OPEN)));
    assert_desel_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (ce_hi_cnt >= CNT_W'(N_DES)));
    assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $stable(mem_addr));
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));
    assert_release_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));
    assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && !(mem_ub_n && mem_lb_n) && mem_dq_oe));
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n));
    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/psram_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_ctrl_tb_top;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int N_RD = 14;
    localparam int N_WR = 14;
    localparam int N_DES = 3;
    localparam int N_OE = 7;
    localparam int N_OPEN = 8000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, req_valid, req_ready, req_write, rsp_valid;
    logic [AW-1:0] req_addr, mem_addr;
    logic [1:0] req_lanes;
    logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    psram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_lanes(req_lanes),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model: returns a marker unless the full windows have elapsed
    logic [DW-1:0] mem [16];
    int ce_run = 0, oe_run = 0, hi_run = 100, we_run = 0, max_ce_run = 0;
    int ce_falls = 0, writes = 0;
    int viol_gap = 0, viol_addr = 0, viol_len = 0, viol_wr = 0, viol_bus = 0;
    bit prev_ce = 1'b1, prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0, saw_we = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] cap_data = '0;
    logic [1:0] cap_lanes = '0;

    always_comb begin
        mem_dq_in = 16'hBAD0;
        if (!mem_ce_n && !mem_oe_n && ce_run >= N_RD && oe_run >= N_OE) begin
            mem_dq_in[7:0]  = mem_lb_n ? 8'hEE : mem[mem_addr[3:0]][7:0];
            mem_dq_in[15:8] = mem_ub_n ? 8'hEE : mem[mem_addr[3:0]][15:8];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ce && !mem_ce_n) begin
                ce_falls++;
                if (hi_run < N_DES) viol_gap++;
                if (mem_addr != prev_addr) viol_addr++;
                saw_we = 1'b0;
            end
            if (!mem_we_n) begin
                saw_we = 1'b1;
                we_run++;
                cap_data = mem_dq_out;
                cap_lanes = {!mem_ub_n, !mem_lb_n};
                if (!mem_dq_oe) viol_wr++;
            end
            if (!prev_we && mem_we_n) begin
                if (we_run != N_WR || !mem_ce_n || !mem_ub_n || !mem_lb_n || !mem_dq_oe) viol_wr++;
                if (cap_lanes[0]) mem[mem_addr[3:0]][7:0]  = cap_data[7:0];
                if (cap_lanes[1]) mem[mem_addr[3:0]][15:8] = cap_data[15:8];
                writes++;
                we_run = 0;
            end
            if (!prev_ce && mem_ce_n) begin
                if (ce_run != (saw_we ? N_WR : N_RD)) viol_len++;
                if (!saw_we && oe_run != N_RD) viol_len++;
            end
            if (mem_dq_oe && !mem_oe_n) viol_bus++;
            if (prev_oe && !mem_oe_n && prev_dqoe) viol_bus++;
            if (mem_ce_n) begin
                ce_run = 0;
                if (hi_run < 100) hi_run++;
            end else begin
                ce_run++;
                hi_run = 0;
                if (ce_run > max_ce_run) max_ce_run = ce_run;
            end
            oe_run = mem_oe_n ? 0 : oe_run + 1;
            prev_ce = mem_ce_n; prev_we = mem_we_n; prev_oe = mem_oe_n;
            prev_dqoe = mem_dq_oe; prev_addr = mem_addr;
        end
    end

    task automatic do_req(input bit wr, input logic [3:0] a, input logic [1:0] ln,
                          input logic [DW-1:0] d, output int t_acc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {16'h0, a};
        req_lanes = ln; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        t_acc = cyc;
        req_valid = 1'b0;
    endtask

    // {write, addr[3:0], lanes[1:0], wdata[15:0], expected read[15:0]}
    localparam logic [38:0] VEC [12] = '{
        {1'b1, 4'h1, 2'b11, 16'h1234, 16'h0000},
        {1'b0, 4'h1, 2'b11, 16'h0000, 16'h1234},
        {1'b1, 4'h1, 2'b01, 16'hABCD, 16'h0000},
        {1'b0, 4'h1, 2'b11, 16'h0000, 16'h12CD},
        {1'b1, 4'h1, 2'b10, 16'h5600, 16'h0000},
        {1'b0, 4'h1, 2'b10, 16'h0000, 16'h5600},
        {1'b0, 4'h1, 2'b01, 16'h0000, 16'h00CD},
        {1'b1, 4'h2, 2'b00, 16'hFFFF, 16'h0000},
        {1'b0, 4'h2, 2'b11, 16'h0000, 16'h0000},
        {1'b1, 4'h3, 2'b11, 16'hBEEF, 16'h0000},
        {1'b0, 4'h3, 2'b11, 16'h0000, 16'hBEEF},
        {1'b0, 4'h2, 2'b00, 16'h0000, 16'h0000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t_a, t_b, falls0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_lanes = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        check(mem_ub_n && mem_lb_n, "R1 lanes", {mem_ub_n, mem_lb_n}, 3);
        check(!mem_dq_oe && req_ready && !rsp_valid, "R1 bus/ready",
              {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n, "R1 after release", {req_ready, mem_ce_n}, 3);

        for (int i = 0; i < 12; i++) begin
            logic [38:0] v;
            bit wr;
            logic [1:0] ln;
            v = VEC[i];
            wr = v[38];
            ln = v[33:32];
            falls0 = ce_falls;
            do_req(wr, v[37:34], ln, v[31:16], t_a);
            if (ln == 2'b00) begin
                // R8: zero mask, no chip-enable activity, still ready
                check(req_ready, "R8 ready after skip", req_ready, 1);
                if (!wr) begin
                    check(rsp_valid && (rsp_rdata == 16'h0), "R8 immediate zero read",
                          {rsp_valid, rsp_rdata}, 17'h10000);
                end
                repeat (3) @(negedge clk);
                check(ce_falls == falls0, "R8 no bus cycle", ce_falls - falls0, 0);
            end else if (!wr) begin
                while (!rsp_valid && (cyc - t_a) < 100) @(negedge clk);
                // R3/R10: response latency 1 + N_RD cycles
                check(cyc - t_a == N_RD + 1, "R3 rsp latency", cyc - t_a, N_RD + 1);
                // R3/R5: data and lane mapping
                check(rsp_rdata == v[15:0], "R3 R5 read data", rsp_rdata, v[15:0]);
                // R2: address on pins
                check(mem_addr[3:0] == v[37:34], "R2 address", mem_addr[3:0], v[37:34]);
                @(negedge clk);
                check(!rsp_valid, "R3 single pulse", rsp_valid, 0);
            end
        end

        // R10: back-to-back writes spaced 1 + N_WR + N_DES + 1 cycles
        do_req(1'b1, 4'h5, 2'b11, 16'hA55A, t_a);
        do_req(1'b1, 4'h6, 2'b11, 16'h5AA5, t_b);
        check(t_b - t_a == N_WR + N_DES + 2, "R10 accept spacing", t_b - t_a, N_WR + N_DES + 2);
        do_req(1'b0, 4'h6, 2'b11, 16'h0, t_a);
        while (!rsp_valid && (cyc - t_a) < 100) @(negedge clk);
        check(rsp_rdata == 16'h5AA5, "R4 write after write", rsp_rdata, 16'h5AA5);
        repeat (25) @(negedge clk);

        check(viol_gap == 0, "R6 deselect gap", viol_gap, 0);
        check(viol_addr == 0, "R2 address stable at CE fall", viol_addr, 0);
        check(viol_len == 0, "R3 R4 cycle length", viol_len, 0);
        check(viol_wr == 0, "R4 write pulse shape", viol_wr, 0);
        check(writes == 6, "R4 write count", writes, 6);
        check(viol_bus == 0, "R7 bus turnaround", viol_bus, 0);
        check(max_ce_run < N_OPEN, "R9 open bound", max_ce_run, N_OPEN);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule